// File: doc/BRIEF.md
# USB Device Link Signal Hold Timer

This block holds one of two device-side USB link signals for a timed interval: the resume line used for remote wakeup, and the soft disconnect line. A one-cycle request pulse starts the interval. The block keeps the selected line asserted for the required time and then releases it. A single microsecond prescaler, driven by the clock frequency parameter, derives every duration.

The resume hold time comes from a programmed count of milliseconds. This count is forced into the 1 to 15 ms range. The disconnect hold time depends on the link speed and the device activity state, both captured when the request is accepted. The block adds a jitter margin to the minimum for that case and rounds the result up to whole microseconds. The block drives a busy flag while a line is held. It also gives a one-cycle done pulse when the line is released.

Top module: `usbsig_timer`

## Requirements
- R1: After reset, resumeOut, disconnectOut, busy and done are all low.
- R2: A wakeup request is accepted only when the block is not busy and devState is 2'b00 (suspended). Otherwise it is ignored and no output changes.
- R3: An accepted wakeup asserts resumeOut from the next cycle for exactly M*1000*CLK_MHZ cycles. M is wakeMs with 0 raised to 1 and values above 15 lowered to 15.
- R4: At high speed (isHighSpeed=1), disconnectOut is held for (1003+JITTER_US) us when suspended (2'b00). It is held for (3003+JITTER_US) us when idle (2'b01), and for (125+JITTER_US) us when active (2'b10 or 2'b11). Each microsecond lasts CLK_MHZ cycles, and the hold starts the cycle after the request.
- R5: At full/low speed (isHighSpeed=0), disconnectOut is held for (1003+JITTER_US) us when suspended and for (3+JITTER_US) us when idle or active.
- R6: The speed and state used for the duration are those present in the request cycle. Later changes during the hold do not alter the length.
- R7: Any request that arrives while busy is high is ignored.
- R8: done is high for exactly one cycle, in the first cycle after the line drops. busy is already low in that cycle, so a request made then is accepted.
- R9: resumeOut and disconnectOut are never high together. When both requests arrive in the same idle cycle, the disconnect is taken and the wakeup is dropped.
- R10: busy is high exactly in the cycles where resumeOut or disconnectOut is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeReq | input | 1 | Remote wakeup request pulse |
| discReq | input | 1 | Soft disconnect request pulse |
| isHighSpeed | input | 1 | 1 = high speed, 0 = full/low speed |
| devState | input | 2 | 00 suspended, 01 idle, 10/11 active |
| wakeMs | input | 5 | Programmed resume time in ms (clamped 1..15) |
| resumeOut | output | 1 | Resume signaling line |
| disconnectOut | output | 1 | Soft disconnect line |
| busy | output | 1 | A line is being held |
| done | output | 1 | One-cycle pulse on release |

## Verification
Two events can fall in the same cycle. The first is the acceptance of a wakeup request and of a disconnect request. The second is a line release and a fresh request. The bench provokes the first by pulsing both requests in one idle cycle while the device is suspended. It judges the result by measuring a full disconnect hold with resume never rising. The bench provokes the second by issuing a request in the done cycle and expects the new line to rise on the next cycle. Both request lines are also pulsed in the middle of holds, while speed and state are flipped, and the measured length must still match the request-cycle case.

// File: rtl/usbsig_pkg.sv
package usbsig_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_WAKE = 2'b01,
    PH_DISC = 2'b10
  } phase_e;

  localparam logic [1:0] DEV_SUSP = 2'b00;
  localparam logic [1:0] DEV_IDLE = 2'b01;

  typedef struct packed {
    logic startWake;
    logic startDisc;
  } ctrlStrobe_t;

endpackage

// File: rtl/usbsig_dp.sv
module usbsig_dp
  import usbsig_pkg::*;
#(
  parameter int CLK_MHZ   = 60,
  parameter int JITTER_US = 10,
  parameter int WAKE_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              isHighSpeed,
  input  logic [1:0]        devState,
  input  logic [WAKE_W-1:0] wakeMs,
  output logic              expire
);

  localparam int HS_SUSP_US = 1003 + JITTER_US;
  localparam int HS_IDLE_US = 3003 + JITTER_US;
  localparam int HS_ACT_US  = 125 + JITTER_US;
  localparam int FS_SUSP_US = 1003 + JITTER_US;
  localparam int FS_REST_US = 3 + JITTER_US;
  localparam int MAX_US     = (HS_IDLE_US > 15000) ? HS_IDLE_US : 15000;
  localparam int US_W       = $clog2(MAX_US + 1);
  localparam int PRE_W      = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

  function automatic int discUsFor(int idx);
    int us;
    if (idx >= 4) begin
      if (idx == 4)      us = HS_SUSP_US;
      else if (idx == 5) us = HS_IDLE_US;
      else               us = HS_ACT_US;
    end else begin
      if (idx == 0) us = FS_SUSP_US;
      else          us = FS_REST_US;
    end
    return us;
  endfunction

  logic [US_W-1:0] discLut [8];
  generate
    for (genvar gi = 0; gi < 8; gi++) begin : g_lut
      assign discLut[gi] = US_W'(discUsFor(gi));
    end
  endgenerate

  logic [US_W-1:0]   discSel, wakeUs, loadUs, usTarget, usCnt;
  logic [WAKE_W-1:0] msClamped;
  logic [PRE_W-1:0]  preCnt;
  logic              running, preWrap;

  assign discSel = discLut[{isHighSpeed, devState}];

  always_comb begin
    if (wakeMs == '0)                  msClamped = WAKE_W'(1);
    else if (wakeMs > WAKE_W'(15))     msClamped = WAKE_W'(15);
    else                               msClamped = wakeMs;
  end

  assign wakeUs  = US_W'(US_W'(msClamped) * US_W'(1000));
  assign loadUs  = strobe.startDisc ? discSel : wakeUs;
  assign preWrap = (preCnt == PRE_W'(CLK_MHZ - 1));
  assign expire  = running && preWrap && (usCnt == US_W'(usTarget - US_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      preCnt   <= '0;
      usCnt    <= '0;
      usTarget <= '0;
    end else if (strobe.startDisc || strobe.startWake) begin
      running  <= 1'b1;
      preCnt   <= '0;
      usCnt    <= '0;
      usTarget <= loadUs;
    end else if (running) begin
      if (expire) running <= 1'b0;
      if (preWrap) begin
        preCnt <= '0;
        usCnt  <= usCnt + US_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // R6: the captured duration does not move while the count runs
  assert_target_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> $stable(usTarget));

  // R3: the elapsed microsecond count stays below the captured target
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (usCnt < usTarget));

endmodule

// File: rtl/usbsig_ctrl.sv
module usbsig_ctrl
  import usbsig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wakeReq,
  input  logic        discReq,
  input  logic [1:0]  devState,
  input  logic        expire,
  output ctrlStrobe_t strobe,
  output logic        resumeOut,
  output logic        disconnectOut,
  output logic        busy,
  output logic        done
);

  phase_e phase;
  logic   doneQ;

  always_comb begin
    strobe = '0;
    if (phase == PH_IDLE) begin
      if (discReq)                             strobe.startDisc = 1'b1;
      else if (wakeReq && devState == DEV_SUSP) strobe.startWake = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (strobe.startDisc)      phase <= PH_DISC;
          else if (strobe.startWake) phase <= PH_WAKE;
        end
        PH_WAKE, PH_DISC: begin
          if (expire) begin
            phase <= PH_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign resumeOut     = (phase == PH_WAKE);
  assign disconnectOut = (phase == PH_DISC);
  assign busy          = (phase != PH_IDLE);
  assign done          = doneQ;

  assert_lines_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(resumeOut && disconnectOut));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_on_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_wake_from_suspend_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumeOut) |-> ($past(devState) == DEV_SUSP));

  assert_no_start_when_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !expire) |=> $stable(phase));

endmodule

// File: rtl/usbsig_timer.sv
module usbsig_timer
  import usbsig_pkg::*;
#(
  parameter int CLK_MHZ   = 60,
  parameter int JITTER_US = 10,
  parameter int WAKE_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakeReq,
  input  logic              discReq,
  input  logic              isHighSpeed,
  input  logic [1:0]        devState,
  input  logic [WAKE_W-1:0] wakeMs,
  output logic              resumeOut,
  output logic              disconnectOut,
  output logic              busy,
  output logic              done
);

  ctrlStrobe_t strobe;
  logic        expire;

  usbsig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .discReq(discReq),
    .devState(devState), .expire(expire), .strobe(strobe),
    .resumeOut(resumeOut), .disconnectOut(disconnectOut),
    .busy(busy), .done(done)
  );

  usbsig_dp #(.CLK_MHZ(CLK_MHZ), .JITTER_US(JITTER_US), .WAKE_W(WAKE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isHighSpeed(isHighSpeed),
    .devState(devState), .wakeMs(wakeMs), .expire(expire)
  );

endmodule

// File: tb/sim_usbsig_timer.sv
module sim_usbsig_timer;
  localparam int CLK_MHZ = 2;
  localparam int JIT     = 5;

  logic clk = 0, rstN = 0, wakeReq = 0, discReq = 0, isHighSpeed = 0;
  logic [1:0] devState = 2'b00;
  logic [4:0] wakeMs = 5'd1;
  logic resumeOut, disconnectOut, busy, done;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  usbsig_timer #(.CLK_MHZ(CLK_MHZ), .JITTER_US(JIT), .WAKE_W(5)) u0 (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .discReq(discReq),
    .isHighSpeed(isHighSpeed), .devState(devState), .wakeMs(wakeMs),
    .resumeOut(resumeOut), .disconnectOut(disconnectOut), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int discUs(input bit hs, input logic [1:0] st);
    if (st == 2'b00) return 1003 + JIT;
    if (hs) return (st == 2'b01) ? 3003 + JIT : 125 + JIT;
    return 3 + JIT;
  endfunction

  function automatic int wakeCycles(input logic [4:0] ms);
    int m = (ms == 0) ? 1 : (ms > 15 ? 15 : int'(ms));
    return m * 1000 * CLK_MHZ;
  endfunction

  task automatic runReq(input bit w, input bit d, input bit hs, input logic [1:0] st,
                        input logic [4:0] ms, input string tag);
    int exp, cnt;
    bit isDisc, none, bad;
    isDisc = d;
    none   = !d && !(w && st == 2'b00);
    exp    = d ? discUs(hs, st) * CLK_MHZ : wakeCycles(ms);
    @(negedge clk);
    wakeReq = w; discReq = d; isHighSpeed = hs; devState = st; wakeMs = ms;
    @(negedge clk);
    wakeReq = 0; discReq = 0;
    if (none) begin
      repeat (3) begin
        chk(!busy && !resumeOut && !disconnectOut && !done, {tag, " R2 ignored"},
            {busy, resumeOut, disconnectOut, done}, 0);
        @(negedge clk);
      end
      return;
    end
    cnt = 0; bad = 0;
    while ((isDisc ? disconnectOut : resumeOut) && cnt < 40000) begin
      cnt++;
      if ((isDisc ? resumeOut : disconnectOut) || !busy || done) bad = 1;
      if (cnt == 3) begin
        isHighSpeed = !hs; devState = ~st; wakeMs = ~ms;
        wakeReq = 1; discReq = 1;
      end
      if (cnt == 4) begin wakeReq = 0; discReq = 0; end
      @(negedge clk);
    end
    chk(!bad, {tag, " R7 R9 R10 hold"}, bad, 0);
    chk(cnt == exp, {tag, isDisc ? " R4 R5 R6 disc length" : " R3 R6 wake length"}, cnt, exp);
    chk(done && !busy && !resumeOut && !disconnectOut, {tag, " R8 done on release"},
        {done, busy}, 2);
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 done one cycle"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!resumeOut && !disconnectOut && !busy && !done, "R1 reset",
        {resumeOut, disconnectOut, busy, done}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!resumeOut && !disconnectOut && !busy && !done, "R1 after release",
        {resumeOut, disconnectOut, busy, done}, 0);

    runReq(1, 0, 1, 2'b00, 5'd0,  "wake ms0 clamp");
    runReq(1, 0, 1, 2'b00, 5'd31, "wake ms31 clamp");
    runReq(1, 0, 0, 2'b00, 5'd3,  "wake ms3");
    runReq(1, 0, 1, 2'b01, 5'd2,  "wake idle");
    runReq(1, 0, 0, 2'b10, 5'd2,  "wake active");
    runReq(0, 1, 1, 2'b00, 5'd1,  "hs susp");
    runReq(0, 1, 1, 2'b01, 5'd1,  "hs idle");
    runReq(0, 1, 1, 2'b10, 5'd1,  "hs active");
    runReq(0, 1, 1, 2'b11, 5'd1,  "hs active11");
    runReq(0, 1, 0, 2'b00, 5'd1,  "fs susp");
    runReq(0, 1, 0, 2'b01, 5'd1,  "fs idle");
    runReq(0, 1, 0, 2'b10, 5'd1,  "fs active");
    runReq(1, 1, 0, 2'b00, 5'd2,  "both same cycle R9");

    // R8: request during the done cycle is accepted
    @(negedge clk);
    isHighSpeed = 0; devState = 2'b01; discReq = 1;
    @(negedge clk);
    discReq = 0;
    cnt = 0;
    while (disconnectOut && cnt < 100) begin cnt++; @(negedge clk); end
    chk(done, "R8 first done", done, 1);
    discReq = 1; devState = 2'b10;
    @(negedge clk);
    discReq = 0;
    chk(disconnectOut && busy, "R8 accept in done cycle", {disconnectOut, busy}, 3);
    cnt = 1;
    while (disconnectOut && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == (3 + JIT) * CLK_MHZ + 1, "R5 back-to-back length", cnt, (3 + JIT) * CLK_MHZ + 1);

    for (int i = 0; i < 8; i++) begin
      bit w = $urandom_range(1, 0) == 1;
      runReq(w, !w, $urandom_range(1, 0) == 1, 2'($urandom_range(3, 0)),
             5'($urandom_range(3, 0)), "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule